// File: doc/BRIEF.md
# Peripheral Interrupt and Soft-Reset Unit

This unit sits beside a serial-peripheral core and turns that core's single-cycle event pulses into a level interrupt for the host. Every event source owns one bit of a sticky status register, which latches on the rising edge of the event no matter how the enables are set. A per-source enable register chooses which latched bits count toward the interrupt. A single global enable bit then gates the combined request before it reaches the interrupt line, which is registered. Software acknowledges sources by writing ones to the status register, so writing back a value it has just read clears exactly the bits it saw.

The same register port also carries a soft-reset register. Writing the exact key value there starts a reset pulse of fixed length. The pulse is driven out to the rest of the peripheral, and for its whole length it clears every register of this unit. Any other value written to that address is discarded.

The host reaches four word registers through a simple 32-bit port: one address, a write strobe and write data, with combinational read data. The map is: word 0 holds the status, word 1 the enables, word 2 the global enable in bit 31, and word 3 the reset key.

Top module: `intr_reset_unit`

## Requirements
- R1: After rstN is released, irqOut and swResetOut are low and all four word addresses read 0.
- R2: A rising edge on srcEvent[i] sets status bit i whatever the enable setting. A level held high sets the bit only once. Source bit order, shared by status and enable: 0 mode fault, 1 slave-select fault, 2 transmit queue empty, 3 transmit underrun, 4 receive queue full, 5 receive overrun.
- R3: A write to word 0 clears each status bit whose write-data bit is 1 and leaves the others unchanged, so writing back a value read from word 0 clears exactly the bits that were set.
- R4: When an event rising edge and a clear of the same status bit fall in one cycle, the bit ends up set.
- R5: irqOut is high in the cycle after the global bit is set and some status bit has its enable bit set. It is low in the cycle after either of these stops being true.
- R6: Writing 0 to word 1 masks every source: irqOut goes low one cycle later, and the status bits are kept.
- R7: Only bit 31 of word 2 is stored. It gates irqOut, reads back in bit 31, and all other bits of word 2 read 0.
- R8: Writing exactly 0x0000000A to word 3 raises swResetOut in the next cycle and holds it high for RST_CYCLES cycles (default 4).
- R9: While swResetOut is high, status, enable and global enable are cleared and irqOut goes low; all of them read 0 after the pulse.
- R10: Writing any value other than 0x0000000A to word 3 produces no pulse and changes no register.
- R11: The enable register reads back in the low NUM_SRC bits of word 1, and word 3 always reads 0.
- R12: Register writes and source events that arrive while swResetOut is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busAddr | input | ADDR_W | Word address for both reads and writes |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data of the addressed word |
| srcEvent | input | NUM_SRC | Event pulses from the core, one bit per source |
| irqOut | output | 1 | Registered interrupt request |
| swResetOut | output | 1 | Soft-reset pulse to the peripheral |

## Verification
The sources are exercised in three ways. Each bit alone tells whether the bit positions are wired correctly. All six together, followed by a write-back of the value read, confirms that acknowledges clear exactly the bits seen. A level held over several cycles separates edge detection from level sampling. The interrupt is checked with the enable and global bits switched one at a time, and the sample taken one cycle early shows that the output is registered. A write that clears a bit in the same cycle as that bit's event shows which of the two takes priority. In the reset tests, a key write is set against non-key writes, and the bench pushes writes and events into the middle of the pulse to show that the pulse length and the clearing cannot be disturbed.

// File: rtl/intr_reset_pkg.sv
package intr_reset_pkg;

  // Word addresses of the register port
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_ENABLE = 1;
  localparam int unsigned ADDR_GLOBAL = 2;
  localparam int unsigned ADDR_RESET  = 3;

  // Value that must be written to the reset word to start a pulse
  localparam logic [31:0] RESET_KEY = 32'h0000_000A;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_GLOBAL
  } regSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrGlobal;
    logic clearAll;
  } ctrlStrobes_t;

endpackage

// File: rtl/intr_reset_ctrl.sv
module intr_reset_ctrl
  import intr_reset_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctrlStrobes_t      strobes,
  output regSel_t           rdSel,
  output logic              swResetOut
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic pulseActive;
  logic hitStatus, hitEnable, hitGlobal, hitReset;
  logic keyMatch;

  assign hitStatus = (busAddr == ADDR_W'(ADDR_STATUS));
  assign hitEnable = (busAddr == ADDR_W'(ADDR_ENABLE));
  assign hitGlobal = (busAddr == ADDR_W'(ADDR_GLOBAL));
  assign hitReset  = (busAddr == ADDR_W'(ADDR_RESET));
  assign keyMatch  = (busWrData == DATA_W'(RESET_KEY));

  assign pulseActive = (rstCnt != '0);

  // Reset pulse sequencer: a key write loads the counter, which runs down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (pulseActive) begin
      rstCnt <= rstCnt - CNT_W'(1);
    end else if (busWrEn && hitReset && keyMatch) begin
      rstCnt <= CNT_W'(RST_CYCLES);
    end
  end

  // Write strobes are suppressed for the whole pulse
  always_comb begin
    strobes.wrStatus = busWrEn && hitStatus && !pulseActive;
    strobes.wrEnable = busWrEn && hitEnable && !pulseActive;
    strobes.wrGlobal = busWrEn && hitGlobal && !pulseActive;
    strobes.clearAll = pulseActive;
  end

  always_comb begin
    if (hitStatus)      rdSel = SEL_STATUS;
    else if (hitEnable) rdSel = SEL_ENABLE;
    else if (hitGlobal) rdSel = SEL_GLOBAL;
    else                rdSel = SEL_NONE;
  end

  assign swResetOut = pulseActive;

endmodule

// File: rtl/intr_reset_datapath.sv
module intr_reset_datapath
  import intr_reset_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  regSel_t            rdSel,
  input  logic [NUM_SRC-1:0] wrMask,
  input  logic               wrGlobalBit,
  input  logic [NUM_SRC-1:0] srcEvent,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] enableVec,
  output logic               globalEn,
  output logic               irqOut,
  output logic [DATA_W-1:0]  rdData
);

  localparam int GLOBAL_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] evtPrevQ;
  logic [NUM_SRC-1:0] enableQ;
  logic               globalQ;
  logic               irqQ;

  // Previous event level for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrevQ <= '0;
    else       evtPrevQ <= srcEvent;
  end

  // One sticky status bit per source; clearAll beats the event, the event beats an acknowledge
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic bitQ;
    logic rise;
    assign rise = srcEvent[i] & ~evtPrevQ[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               bitQ <= 1'b0;
      else if (strobes.clearAll)               bitQ <= 1'b0;
      else if (rise)                           bitQ <= 1'b1;
      else if (strobes.wrStatus && wrMask[i])  bitQ <= 1'b0;
    end
    assign statusVec[i] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      globalQ <= 1'b0;
    end else if (strobes.clearAll) begin
      enableQ <= '0;
      globalQ <= 1'b0;
    end else begin
      if (strobes.wrEnable) enableQ <= wrMask;
      if (strobes.wrGlobal) globalQ <= wrGlobalBit;
    end
  end

  // Registered interrupt request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= !strobes.clearAll && globalQ && (|(statusVec & enableQ));
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_STATUS: rdData[NUM_SRC-1:0] = statusVec;
      SEL_ENABLE: rdData[NUM_SRC-1:0] = enableQ;
      SEL_GLOBAL: rdData[GLOBAL_BIT]  = globalQ;
      default:    rdData = '0;
    endcase
  end

  assign enableVec = enableQ;
  assign globalEn  = globalQ;
  assign irqOut    = irqQ;

endmodule

// File: rtl/intr_reset_unit.sv
module intr_reset_unit
  import intr_reset_pkg::*;
#(
  parameter int NUM_SRC    = 6,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcEvent,
  output logic               irqOut,
  output logic               swResetOut
);

  ctrlStrobes_t       strobes;
  regSel_t            rdSel;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] enableVec;
  logic               globalEn;

  intr_reset_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .swResetOut(swResetOut)
  );

  intr_reset_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .wrMask     (busWrData[NUM_SRC-1:0]),
    .wrGlobalBit(busWrData[DATA_W-1]),
    .srcEvent   (srcEvent),
    .statusVec  (statusVec),
    .enableVec  (enableVec),
    .globalEn   (globalEn),
    .irqOut     (irqOut),
    .rdData     (busRdData)
  );

endmodule

// File: rtl/intr_reset_checker.sv
module intr_reset_checker
  import intr_reset_pkg::*;
#(
  parameter int NUM_SRC    = 6,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWrData,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic [NUM_SRC-1:0] statusVec,
  input logic [NUM_SRC-1:0] enableVec,
  input logic               globalEn,
  input logic               irqOut,
  input logic               swResetOut
);

  localparam int PC_W = $clog2(RST_CYCLES + 2);

  logic [NUM_SRC-1:0] prevEvt;
  logic [NUM_SRC-1:0] riseSeen;
  logic [PC_W-1:0]    pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevEvt <= '0;
    else       prevEvt <= srcEvent;
  end
  assign riseSeen = srcEvent & ~prevEvt;

  // Length of the current run of swResetOut
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pulseCnt <= '0;
    else if (swResetOut) pulseCnt <= pulseCnt + PC_W'(1);
    else                 pulseCnt <= '0;
  end

  // R4: an event edge always leaves its status bit set
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (riseSeen != '0 && !swResetOut) |=> ((statusVec & $past(riseSeen)) == $past(riseSeen)));

  // R5: the interrupt is raised only by an enabled, latched source under the global gate
  a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(globalEn && ((statusVec & enableVec) != '0)));

  a_r5_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && ((statusVec & enableVec) != '0) && !swResetOut) |=> irqOut);

  // R8: pulse never exceeds and always reaches its configured length
  a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rstN)
    swResetOut |-> (pulseCnt < PC_W'(RST_CYCLES)));

  a_r8_pulse_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swResetOut) |-> (pulseCnt == PC_W'(RST_CYCLES)));

  // R9: during the pulse everything is held cleared
  a_r9_pulse_clears: assert property (@(posedge clk) disable iff (!rstN)
    swResetOut |=> (statusVec == '0 && enableVec == '0 && !globalEn && !irqOut));

  // R10: a pulse starts only after a key write to the reset word
  a_r10_key_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swResetOut) |-> $past(busWrEn && busAddr == ADDR_W'(ADDR_RESET)
                                && busWrData == DATA_W'(RESET_KEY)));

endmodule

bind intr_reset_unit intr_reset_checker #(
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .srcEvent  (srcEvent),
  .statusVec (statusVec),
  .enableVec (enableVec),
  .globalEn  (globalEn),
  .irqOut    (irqOut),
  .swResetOut(swResetOut)
);

// File: tb/intr_reset_unit_test.sv
module intr_reset_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic [5:0]  srcEvent = 6'd0;
  logic        irqOut;
  logic        swResetOut;

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_GLB  = 2'd2;
  localparam logic [1:0] A_RST  = 2'd3;

  intr_reset_unit uut (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .srcEvent  (srcEvent),
    .irqOut    (irqOut),
    .swResetOut(swResetOut)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 32'd0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulseEvent(logic [5:0] m);
    @(negedge clk);
    srcEvent = m;
    @(negedge clk);
    srcEvent = 6'd0;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);
    check("R1 swResetOut", {31'd0, swResetOut}, 32'd0);
    busRead(A_STAT, v); check("R1 status", v, 32'd0);
    busRead(A_EN, v);   check("R1 enable", v, 32'd0);
    busRead(A_GLB, v);  check("R1 global", v, 32'd0);
    busRead(A_RST, v);  check("R11 reset word reads 0", v, 32'd0);
  endtask

  task automatic testEachSource();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      pulseEvent(6'(1 << i));
      busRead(A_STAT, v); check("R2 single source sets its bit", v, 32'(1 << i));
      @(negedge clk);
      check("R5 no irq while disabled", {31'd0, irqOut}, 32'd0);
      busWrite(A_STAT, 32'd0);
      busRead(A_STAT, v); check("R3 zero write keeps bit", v, 32'(1 << i));
      busWrite(A_STAT, 32'(1 << i));
      busRead(A_STAT, v); check("R3 one write clears bit", v, 32'd0);
    end
  endtask

  task automatic testHeldLevel();
    logic [31:0] v;
    @(negedge clk); srcEvent = 6'h04;
    repeat (3) @(negedge clk);
    busRead(A_STAT, v); check("R2 held level sets", v, 32'h4);
    busWrEn = 1'b1; busAddr = A_STAT; busWrData = 32'h4;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 32'd0;
    repeat (2) @(negedge clk);
    busRead(A_STAT, v); check("R2 held level sets only once", v, 32'd0);
    srcEvent = 6'd0;
    @(negedge clk);
  endtask

  task automatic testWriteBack();
    logic [31:0] v;
    pulseEvent(6'h3F);
    busRead(A_STAT, v); check("R2 all sources", v, 32'h3F);
    busWrite(A_STAT, v);
    busRead(A_STAT, v); check("R3 write-back clears all", v, 32'd0);
    pulseEvent(6'h21);
    busWrite(A_STAT, 32'h01);
    busRead(A_STAT, v); check("R3 partial clear", v, 32'h20);
    busWrite(A_STAT, 32'h20);
  endtask

  task automatic testIrqGating();
    logic [31:0] v;
    busWrite(A_EN, 32'hFFFF_FF04);
    busRead(A_EN, v); check("R11 enable readback", v, 32'h04);
    busWrite(A_GLB, 32'hFFFF_FFFF);
    busRead(A_GLB, v); check("R7 only bit31 stored", v, 32'h8000_0000);
    pulseEvent(6'h08);
    @(negedge clk);
    check("R5 unenabled source no irq", {31'd0, irqOut}, 32'd0);
    busWrite(A_STAT, 32'h08);
    pulseEvent(6'h04);
    check("R5 irq is registered", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R5 irq raised", {31'd0, irqOut}, 32'd1);
    busWrite(A_GLB, 32'h7FFF_FFFF);
    @(negedge clk);
    check("R7 global gate off", {31'd0, irqOut}, 32'd0);
    busRead(A_GLB, v); check("R7 low bits not stored", v, 32'd0);
    busWrite(A_GLB, 32'h8000_0000);
    @(negedge clk);
    check("R7 global gate on", {31'd0, irqOut}, 32'd1);
    busWrite(A_EN, 32'd0);
    @(negedge clk);
    check("R6 zero enable masks", {31'd0, irqOut}, 32'd0);
    busRead(A_STAT, v); check("R6 status kept", v, 32'h04);
    busWrite(A_STAT, 32'h04);
  endtask

  task automatic testSameCycle();
    logic [31:0] v;
    pulseEvent(6'h02);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = A_STAT; busWrData = 32'h02; srcEvent = 6'h02;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 32'd0; srcEvent = 6'd0;
    busRead(A_STAT, v); check("R4 event beats clear", v, 32'h02);
    busWrite(A_STAT, 32'h02);
    busRead(A_STAT, v); check("R4 later clear works", v, 32'd0);
  endtask

  task automatic testNonKey();
    logic [31:0] v;
    int seen;
    busWrite(A_EN, 32'h15);
    busWrite(A_GLB, 32'h8000_0000);
    pulseEvent(6'h01);
    seen = 0;
    busWrite(A_RST, 32'h0000_000B);
    if (swResetOut) seen++;
    busWrite(A_RST, 32'h0000_010A);
    if (swResetOut) seen++;
    busWrite(A_RST, 32'd0);
    for (int k = 0; k < 6; k++) begin
      if (swResetOut) seen++;
      @(negedge clk);
    end
    check("R10 no pulse from non-key", 32'(seen), 32'd0);
    busRead(A_EN, v);   check("R10 enable unchanged", v, 32'h15);
    busRead(A_GLB, v);  check("R10 global unchanged", v, 32'h8000_0000);
    busRead(A_STAT, v); check("R10 status unchanged", v, 32'h01);
    check("R10 irq unchanged", {31'd0, irqOut}, 32'd1);
  endtask

  task automatic testKeyReset();
    logic [31:0] v;
    busWrite(A_EN, 32'h3F);
    pulseEvent(6'h12);
    @(negedge clk);
    check("R5 irq before reset", {31'd0, irqOut}, 32'd1);
    busWrite(A_RST, 32'h0000_000A);
    for (int k = 0; k < 4; k++) begin
      check("R8 pulse high", {31'd0, swResetOut}, 32'd1);
      if (k == 1) begin
        check("R9 irq low during pulse", {31'd0, irqOut}, 32'd0);
        busWrEn = 1'b1; busAddr = A_EN; busWrData = 32'h3F; srcEvent = 6'h3F;
      end
      if (k == 2) begin
        busWrEn = 1'b1; busAddr = A_GLB; busWrData = 32'h8000_0000; srcEvent = 6'd0;
      end
      if (k == 3) begin
        busWrEn = 1'b0; busWrData = 32'd0;
      end
      @(negedge clk);
    end
    check("R8 pulse ends after RST_CYCLES", {31'd0, swResetOut}, 32'd0);
    busRead(A_STAT, v); check("R9 R12 status cleared", v, 32'd0);
    busRead(A_EN, v);   check("R9 R12 enable cleared", v, 32'd0);
    busRead(A_GLB, v);  check("R9 R12 global cleared", v, 32'd0);
    check("R9 irq low after pulse", {31'd0, irqOut}, 32'd0);
    pulseEvent(6'h08);
    busRead(A_STAT, v); check("R2 events work after pulse", v, 32'h08);
    @(negedge clk);
    check("R9 enables stay cleared", {31'd0, irqOut}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testEachSource();
    testHeldLevel();
    testWriteBack();
    testIrqGating();
    testSameCycle();
    testNonKey();
    testKeyReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule